// File: doc/BRIEF.md
# PC Card Byte Lane Steering

This block sits between a 16-bit PC card host bus and two byte-wide flash devices organised as an even/odd pair. From the two card enables, address bit 0, the read and write strobes and the attribute-space select, it works out which bytes move and in which direction. It then routes each byte onto the correct host lane, or to the correct device. It drives each device's read and write strobes only for the bytes that take part. It also drives the host lane output enables only during a valid read.

An 8-bit host keeps the high enable inactive and uses address bit 0 to reach both devices through the low lane. A 16-bit host asserts both enables for a word. A host that asserts only the high enable reaches the odd device through the high lane. In attribute space only the even device is reachable. The odd device is never strobed there, and any lane that would carry odd data returns a fixed fill byte. All outputs are registered and follow the sampled inputs by one clock.

Top module: `pcc_lane_steer`

## Requirements
- R1: While `rst` is high, and on the first sampling after it, all four device strobes are high, both lane enables are low, `host_rdata` is zero, both device write data buses are zero and `xfer_mode` is 0.
- R2: With both card enables high (standby), `xfer_mode` is 0 and no device strobe or lane enable is asserted, whatever the other inputs are.
- R3: `xfer_mode` encodes the enables and address bit 0 as follows. lo_n=0, hi_n=1, a0=0 gives 1 (even byte). lo_n=0, hi_n=1, a0=1 gives 2 (odd byte on the low lane). Both enables low gives 3 (word), with a0 ignored. lo_n=1, hi_n=0 gives 4 (odd byte on the high lane).
- R4: A read needs `host_rd_n`=0 and `host_wr_n`=1. A write needs `host_wr_n`=0 and `host_rd_n`=1. Both low or both high strobes nothing and enables no lane.
- R5: A mode-1 read strobes only the even device, places its byte on `host_rdata[7:0]` and enables only the low lane.
- R6: A mode-2 read in common memory strobes only the odd device, places its byte on `host_rdata[7:0]` and enables only the low lane.
- R7: A mode-3 read strobes both devices, with the odd byte on `host_rdata[15:8]` and the even byte on `host_rdata[7:0]`, and enables both lanes.
- R8: A mode-4 read strobes only the odd device, places its byte on `host_rdata[15:8]` and enables only the high lane.
- R9: On writes, modes 1 and 2 send `host_wdata[7:0]` to the even or odd device respectively. Mode 3 sends the low byte to the even device and the high byte to the odd device. Mode 4 sends the high byte to the odd device. Only the devices that receive data are strobed, and a device's write data is zero when it is not strobed.
- R10: With `host_attr_n`=0 the odd device is never strobed for read or write. Any lane that would carry odd read data returns the fill byte (default 8'hFF).
- R11: The lane enables are asserted only for a valid read.
- R12: Every output reflects the inputs sampled at the previous rising clock edge and holds between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_en_lo_n | input | 1 | Card enable for the even byte, active low |
| card_en_hi_n | input | 1 | Card enable for the odd byte, active low |
| host_a0 | input | 1 | Host address bit 0 |
| host_rd_n | input | 1 | Host output enable, active low |
| host_wr_n | input | 1 | Host write enable, active low |
| host_attr_n | input | 1 | Attribute-space select, active low |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the host lanes |
| lane_oe_lo | output | 1 | Drive enable for host lane 7:0 |
| lane_oe_hi | output | 1 | Drive enable for host lane 15:8 |
| xfer_mode | output | 3 | Decoded transfer mode (R3 encoding) |
| even_rdata | input | 8 | Read data from the even device |
| odd_rdata | input | 8 | Read data from the odd device |
| even_wdata | output | 8 | Write data to the even device |
| odd_wdata | output | 8 | Write data to the odd device |
| even_rd_n | output | 1 | Even device read strobe, active low |
| odd_rd_n | output | 1 | Odd device read strobe, active low |
| even_wr_n | output | 1 | Even device write strobe, active low |
| odd_wr_n | output | 1 | Odd device write strobe, active low |

## Verification
The bench sends an odd-byte access through the low lane and a high-enable-only access through the high lane, so that swapped lanes show up as a wrong byte on an enabled lane. It repeats word accesses with address bit 0 at both values, which catches a decoder that lets A0 leak into word mode. It also drives both host strobes low at once, where a design with a loose read or write decode would strobe a device or drive the bus into contention. Odd accesses in attribute space must leave the odd device untouched and return the fill byte, so a missing attribute gate shows up as an odd strobe or as device data on the lane.

// File: rtl/pcc_lane_pkg.sv
package pcc_lane_pkg;

    localparam int BYTE_W_DEF = 8;

    typedef enum logic [2:0] {
        XM_IDLE = 3'd0,
        XM_EVEN = 3'd1,
        XM_ODD  = 3'd2,
        XM_WORD = 3'd3,
        XM_HIGH = 3'd4
    } xfer_mode_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        xfer_mode_e mode;
        op_e        op;
        logic       attr;
    } bus_dec_t;

    // Device index within the pair
    localparam int DEV_EVEN = 0;
    localparam int DEV_ODD  = 1;
    localparam int N_DEV    = 2;

    function automatic xfer_mode_e decode_mode(input logic lo_n, input logic hi_n,
                                               input logic a0);
        xfer_mode_e m;
        unique case ({lo_n, hi_n})
            2'b11:   m = XM_IDLE;
            2'b00:   m = XM_WORD;
            2'b10:   m = XM_HIGH;
            default: m = a0 ? XM_ODD : XM_EVEN;
        endcase
        return m;
    endfunction

    function automatic op_e decode_op(input logic rd_n, input logic wr_n);
        op_e o;
        unique case ({rd_n, wr_n})
            2'b01:   o = OP_READ;
            2'b10:   o = OP_WRITE;
            default: o = OP_NONE;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pcc_lane_decode.sv
module pcc_lane_decode
    import pcc_lane_pkg::*;
(
    input  logic     en_lo_n,
    input  logic     en_hi_n,
    input  logic     a0,
    input  logic     rd_n,
    input  logic     wr_n,
    input  logic     attr_n,
    output bus_dec_t dec
);

    always_comb begin
        dec.mode = decode_mode(en_lo_n, en_hi_n, a0);
        dec.op   = (dec.mode == XM_IDLE) ? OP_NONE : decode_op(rd_n, wr_n);
        dec.attr = !attr_n;
    end

endmodule

// File: rtl/pcc_read_mux.sv
module pcc_read_mux
    import pcc_lane_pkg::*;
#(
    parameter int                BYTE_W    = BYTE_W_DEF,
    parameter logic [BYTE_W-1:0] ATTR_FILL = '1
) (
    input  bus_dec_t                         dec,
    input  logic [BYTE_W-1:0]                even_q,
    input  logic [BYTE_W-1:0]                odd_q,
    output logic [2*BYTE_W-1:0]              host_q,
    output logic                             lane_en_lo,
    output logic                             lane_en_hi,
    output logic [N_DEV-1:0]                 dev_rd
);

    logic [BYTE_W-1:0] odd_eff;
    logic              odd_ok;

    always_comb begin
        odd_ok     = !dec.attr;
        odd_eff    = odd_ok ? odd_q : ATTR_FILL;
        host_q     = '0;
        lane_en_lo = 1'b0;
        lane_en_hi = 1'b0;
        dev_rd     = '0;
        if (dec.op == OP_READ) begin
            unique case (dec.mode)
                XM_EVEN: begin
                    host_q[BYTE_W-1:0] = even_q;
                    lane_en_lo         = 1'b1;
                    dev_rd[DEV_EVEN]   = 1'b1;
                end
                XM_ODD: begin
                    host_q[BYTE_W-1:0] = odd_eff;
                    lane_en_lo         = 1'b1;
                    dev_rd[DEV_ODD]    = odd_ok;
                end
                XM_WORD: begin
                    host_q           = {odd_eff, even_q};
                    lane_en_lo       = 1'b1;
                    lane_en_hi       = 1'b1;
                    dev_rd[DEV_EVEN] = 1'b1;
                    dev_rd[DEV_ODD]  = odd_ok;
                end
                XM_HIGH: begin
                    host_q[2*BYTE_W-1:BYTE_W] = odd_eff;
                    lane_en_hi                = 1'b1;
                    dev_rd[DEV_ODD]           = odd_ok;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pcc_write_steer.sv
module pcc_write_steer
    import pcc_lane_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  bus_dec_t                         dec,
    input  logic [2*BYTE_W-1:0]              host_d,
    output logic [N_DEV-1:0][BYTE_W-1:0]     dev_d,
    output logic [N_DEV-1:0]                 dev_wr
);

    logic [BYTE_W-1:0] lo_b, hi_b;
    logic              odd_ok;

    always_comb begin
        lo_b   = host_d[BYTE_W-1:0];
        hi_b   = host_d[2*BYTE_W-1:BYTE_W];
        odd_ok = !dec.attr;
        dev_wr = '0;
        if (dec.op == OP_WRITE) begin
            unique case (dec.mode)
                XM_EVEN: dev_wr[DEV_EVEN] = 1'b1;
                XM_ODD:  dev_wr[DEV_ODD]  = odd_ok;
                XM_WORD: begin
                    dev_wr[DEV_EVEN] = 1'b1;
                    dev_wr[DEV_ODD]  = odd_ok;
                end
                XM_HIGH: dev_wr[DEV_ODD] = odd_ok;
                default: ;
            endcase
        end
        // Byte-wide modes take the low lane; word and high-only take lane per device
        dev_d[DEV_EVEN] = dev_wr[DEV_EVEN] ? lo_b : '0;
        dev_d[DEV_ODD]  = !dev_wr[DEV_ODD] ? '0 :
                          (dec.mode == XM_ODD) ? lo_b : hi_b;
    end

endmodule

// File: rtl/pcc_lane_steer.sv
module pcc_lane_steer
    import pcc_lane_pkg::*;
#(
    parameter int                BYTE_W    = BYTE_W_DEF,
    parameter logic [BYTE_W-1:0] ATTR_FILL = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                card_en_lo_n,
    input  logic                card_en_hi_n,
    input  logic                host_a0,
    input  logic                host_rd_n,
    input  logic                host_wr_n,
    input  logic                host_attr_n,
    input  logic [2*BYTE_W-1:0] host_wdata,
    output logic [2*BYTE_W-1:0] host_rdata,
    output logic                lane_oe_lo,
    output logic                lane_oe_hi,
    output logic [2:0]          xfer_mode,
    input  logic [BYTE_W-1:0]   even_rdata,
    input  logic [BYTE_W-1:0]   odd_rdata,
    output logic [BYTE_W-1:0]   even_wdata,
    output logic [BYTE_W-1:0]   odd_wdata,
    output logic                even_rd_n,
    output logic                odd_rd_n,
    output logic                even_wr_n,
    output logic                odd_wr_n
);

    localparam int HOST_W = 2 * BYTE_W;

    bus_dec_t                       dec;
    logic [HOST_W-1:0]              rd_data_c;
    logic                           en_lo_c, en_hi_c;
    logic [N_DEV-1:0]               rd_sel, wr_sel;
    logic [N_DEV-1:0][BYTE_W-1:0]   wr_data_c;

    pcc_lane_decode u_dec (
        .en_lo_n (card_en_lo_n),
        .en_hi_n (card_en_hi_n),
        .a0      (host_a0),
        .rd_n    (host_rd_n),
        .wr_n    (host_wr_n),
        .attr_n  (host_attr_n),
        .dec     (dec)
    );

    pcc_read_mux #(.BYTE_W(BYTE_W), .ATTR_FILL(ATTR_FILL)) u_rmux (
        .dec        (dec),
        .even_q     (even_rdata),
        .odd_q      (odd_rdata),
        .host_q     (rd_data_c),
        .lane_en_lo (en_lo_c),
        .lane_en_hi (en_hi_c),
        .dev_rd     (rd_sel)
    );

    pcc_write_steer #(.BYTE_W(BYTE_W)) u_wst (
        .dec    (dec),
        .host_d (host_wdata),
        .dev_d  (wr_data_c),
        .dev_wr (wr_sel)
    );

    // Host-facing registers
    xfer_mode_e        mode_q;
    logic [HOST_W-1:0] rdata_q;
    logic              en_lo_q, en_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= XM_IDLE;
            rdata_q <= '0;
            en_lo_q <= 1'b0;
            en_hi_q <= 1'b0;
        end else begin
            mode_q  <= dec.mode;
            rdata_q <= rd_data_c;
            en_lo_q <= en_lo_c;
            en_hi_q <= en_hi_c;
        end
    end

    // Device-facing registers, one slice per device of the pair
    logic [N_DEV-1:0]             rd_n_q, wr_n_q;
    logic [N_DEV-1:0][BYTE_W-1:0] wdata_q;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_n_q[g]  <= 1'b1;
                wr_n_q[g]  <= 1'b1;
                wdata_q[g] <= '0;
            end else begin
                rd_n_q[g]  <= !rd_sel[g];
                wr_n_q[g]  <= !wr_sel[g];
                wdata_q[g] <= wr_data_c[g];
            end
        end
    end

    assign xfer_mode  = mode_q;
    assign host_rdata = rdata_q;
    assign lane_oe_lo = en_lo_q;
    assign lane_oe_hi = en_hi_q;
    assign even_rd_n  = rd_n_q[DEV_EVEN];
    assign odd_rd_n   = rd_n_q[DEV_ODD];
    assign even_wr_n  = wr_n_q[DEV_EVEN];
    assign odd_wr_n   = wr_n_q[DEV_ODD];
    assign even_wdata = wdata_q[DEV_EVEN];
    assign odd_wdata  = wdata_q[DEV_ODD];

    // Lanes are driven only after a cycle with a proper read strobe pair
    assert_lane_only_read_R11: assert property (@(posedge clk) disable iff (rst)
        (lane_oe_lo || lane_oe_hi) |-> ($past(!host_rd_n) && $past(host_wr_n)));

    // No device ever sees read and write at once
    assert_no_rd_wr_clash_R4: assert property (@(posedge clk) disable iff (rst)
        !((!even_rd_n && !even_wr_n) || (!odd_rd_n && !odd_wr_n)));

    // Attribute space never touches the odd device
    assert_attr_odd_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!host_attr_n) |-> (odd_rd_n && odd_wr_n));

    // Standby leaves every strobe and lane quiet
    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        $past(card_en_lo_n && card_en_hi_n) |->
        (xfer_mode == 3'd0 && even_rd_n && odd_rd_n && even_wr_n && odd_wr_n &&
         !lane_oe_lo && !lane_oe_hi));

    // A word read always drives both lanes together
    assert_word_both_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        (xfer_mode == 3'd3 && (lane_oe_lo || lane_oe_hi)) |-> (lane_oe_lo && lane_oe_hi));

endmodule

// File: tb/pcc_lane_steer_test.sv
module pcc_lane_steer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_lo_n = 1'b1, en_hi_n = 1'b1, a0 = 1'b0;
    logic        rd_n = 1'b1, wr_n = 1'b1, attr_n = 1'b1;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        oe_lo, oe_hi;
    logic [2:0]  mode;
    logic [7:0]  ev_rd = 8'h5A, od_rd = 8'hC3;
    logic [7:0]  ev_wd, od_wd;
    logic        ev_rd_n, od_rd_n, ev_wr_n, od_wr_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pcc_lane_steer uut (
        .clk(clk), .rst(rst),
        .card_en_lo_n(en_lo_n), .card_en_hi_n(en_hi_n), .host_a0(a0),
        .host_rd_n(rd_n), .host_wr_n(wr_n), .host_attr_n(attr_n),
        .host_wdata(wdata), .host_rdata(rdata),
        .lane_oe_lo(oe_lo), .lane_oe_hi(oe_hi), .xfer_mode(mode),
        .even_rdata(ev_rd), .odd_rdata(od_rd),
        .even_wdata(ev_wd), .odd_wdata(od_wd),
        .even_rd_n(ev_rd_n), .odd_rd_n(od_rd_n),
        .even_wr_n(ev_wr_n), .odd_wr_n(od_wr_n)
    );

    typedef struct packed {
        logic        lo_n, hi_n, a0, rd_n, wr_n, attr_n;
        logic [15:0] wd;
        logic [3:0]  req;
        logic [2:0]  mode;
        logic        oe_lo, oe_hi;
        logic [15:0] rd;
        logic        erd, ord, ewr, owr;
        logic [7:0]  ew, ow;
    } vec_t;

    localparam int NV = 21;
    // lo_n hi_n a0 rd_n wr_n attr_n wd req mode oelo oehi rd erd ord ewr owr ew ow
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'hA1B2,4'd2, 3'd0,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00}, // R2 read in standby
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,16'hA1B2,4'd5, 3'd1,1'b1,1'b0,16'h005A,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00}, // R5
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,16'hA1B2,4'd6, 3'd2,1'b1,1'b0,16'h00C3,1'b1,1'b0,1'b1,1'b1,8'h00,8'h00}, // R6
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,16'hA1B2,4'd7, 3'd3,1'b1,1'b1,16'hC35A,1'b0,1'b0,1'b1,1'b1,8'h00,8'h00}, // R7
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,16'hA1B2,4'd7, 3'd3,1'b1,1'b1,16'hC35A,1'b0,1'b0,1'b1,1'b1,8'h00,8'h00}, // R7 A0 ignored
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,16'hA1B2,4'd8, 3'd4,1'b0,1'b1,16'hC300,1'b1,1'b0,1'b1,1'b1,8'h00,8'h00}, // R8
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'hA1B2,4'd8, 3'd4,1'b0,1'b1,16'hC300,1'b1,1'b0,1'b1,1'b1,8'h00,8'h00}, // R8
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,16'hA1B2,4'd9, 3'd1,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,1'b1,8'hB2,8'h00}, // R9 even byte
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,16'hA1B2,4'd9, 3'd2,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b1,1'b0,8'h00,8'hB2}, // R9 odd via low lane
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,16'hA1B2,4'd9, 3'd3,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,1'b0,8'hB2,8'hA1}, // R9 word
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,16'hA1B2,4'd9, 3'd4,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b1,1'b0,8'h00,8'hA1}, // R9 high only
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,16'hA1B2,4'd2, 3'd0,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00}, // R2 write in standby
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'hA1B2,4'd4, 3'd3,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00}, // R4 both strobes low
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,16'hA1B2,4'd4, 3'd3,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00}, // R4 no strobe
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,16'hA1B2,4'd10,3'd1,1'b1,1'b0,16'h005A,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00}, // R10 even ok
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,16'hA1B2,4'd10,3'd2,1'b1,1'b0,16'h00FF,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00}, // R10 odd read fill
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,16'hA1B2,4'd10,3'd3,1'b1,1'b1,16'hFF5A,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00}, // R10 word read
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'hA1B2,4'd10,3'd4,1'b0,1'b1,16'hFF00,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00}, // R10 high only
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'hA1B2,4'd10,3'd2,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00}, // R10 odd write dropped
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'hA1B2,4'd10,3'd3,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,1'b1,8'hB2,8'h00}, // R10 word write
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'hA1B2,4'd10,3'd1,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,1'b1,8'hB2,8'h00}  // R10 even write
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        en_lo_n = v.lo_n; en_hi_n = v.hi_n; a0 = v.a0;
        rd_n = v.rd_n; wr_n = v.wr_n; attr_n = v.attr_n; wdata = v.wd;
    endtask

    task automatic check_vec(input vec_t v);
        string r;
        r = $sformatf("R%0d", v.req);
        chk("R3", "xfer_mode", 32'(mode), 32'(v.mode));
        chk("R11", "lane_oe_lo", 32'(oe_lo), 32'(v.oe_lo));
        chk("R11", "lane_oe_hi", 32'(oe_hi), 32'(v.oe_hi));
        chk(r, "host_rdata", 32'(rdata), 32'(v.rd));
        chk(r, "even_rd_n", 32'(ev_rd_n), 32'(v.erd));
        chk(r, "odd_rd_n", 32'(od_rd_n), 32'(v.ord));
        chk(r, "even_wr_n", 32'(ev_wr_n), 32'(v.ewr));
        chk(r, "odd_wr_n", 32'(od_wr_n), 32'(v.owr));
        chk(r, "even_wdata", 32'(ev_wd), 32'(v.ew));
        chk(r, "odd_wdata", 32'(od_wd), 32'(v.ow));
    endtask

    task automatic check_quiet(input string req);
        vec_t q;
        q = VECS[0];
        q.mode = 3'd0;
        chk(req, "xfer_mode", 32'(mode), 32'(q.mode));
        chk(req, "lane_oe_lo", 32'(oe_lo), 32'd0);
        chk(req, "lane_oe_hi", 32'(oe_hi), 32'd0);
        chk(req, "host_rdata", 32'(rdata), 32'd0);
        chk(req, "strobes", 32'({ev_rd_n, od_rd_n, ev_wr_n, od_wr_n}), 32'hF);
        chk(req, "wdata", 32'({ev_wd, od_wd}), 32'd0);
    endtask

    initial begin
        // R1: active inputs during reset must not leak through
        drive(VECS[3]);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i]);
        end

        // R12: outputs hold the previous edge's result while inputs change
        @(negedge clk);
        drive(VECS[3]);
        @(posedge clk);
        #1;
        drive(VECS[0]);
        #1;
        chk("R12", "held host_rdata", 32'(rdata), 32'h0000C35A);
        chk("R12", "held lanes", 32'({oe_lo, oe_hi}), 32'h3);
        @(negedge clk);
        chk("R12", "next edge lanes", 32'({oe_lo, oe_hi}), 32'h0);

        // R1: reset in the middle of an active write
        @(negedge clk);
        drive(VECS[9]);
        @(negedge clk);
        chk("R9", "write before reset", 32'({ev_wr_n, od_wr_n}), 32'h0);
        rst = 1'b1;
        @(negedge clk);
        check_quiet("R1");
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule